// File: doc/BRIEF.md
# Strobed Handshake Parallel Port Controller

This block runs two 8-bit parallel ports (A and B) and a 6-bit port C from a small byte-wide register interface. Software writes a command byte that sets the direction of ports A and B, the interrupt enables, and a 2-bit mode for port C. Port C can be six plain inputs, six plain outputs, or it can give up some of its pins as handshake lines. Those lines are an active-low strobe input, a buffer-full output and an interrupt output. Port C can carry them for port A alone or for both ports.

A port whose handshake lines are active works in strobed mode. As an input, the peripheral's strobe latches the pin data and signals buffer-full. As an output, a register write presents new data and signals buffer-full, and the peripheral's strobe acknowledges the data. Strobe and pin inputs pass through a two-flop synchronizer. The strobe acts on its trailing (rising) edge. Register reads are combinational. A read pulse on a strobed input port clears that port's handshake flags.

Addresses: 0 is the command write and status read, 1 is port A, 2 is port B, 3 is port C.

Top module: `hs_port_ctrl`

## Requirements
- R1: Port C mode 00 (command bits 5:4) makes all six port C pins inputs, and a port C read returns the synchronized pins. Mode 11 makes all six pins outputs that drive the port C latch, and a port C read returns that latch.
- R2: Port C mode 01 hands pins 0, 1 and 2 to port A as interrupt out, buffer-full out and active-low strobe in. Pins 3 to 5 are outputs that drive latch bits 5:3. The output-enable pattern is 6'b111011.
- R3: Port C mode 10 hands pins 0 to 2 to port A and pins 3 to 5 to port B. In each group the order is interrupt out, buffer-full out, strobe in. The output-enable pattern is 6'b011011.
- R4: Command bit 2 sets the direction of port A and bit 3 sets the direction of port B (0 = input, 1 = output). An output port drives its latch with output-enable high, and a read of it returns the latch.
- R5: Command bit 0 enables the port A interrupt and bit 1 enables the port B interrupt. An interrupt pin is high only while its enable is set. A pending request that is masked appears again when the enable is set again.
- R6: Strobed input: a strobe pulse latches the synchronized port data and sets buffer-full and the request. A read of that port returns the latched byte and clears both flags.
- R7: Strobed output: a write to the port drives the byte, sets buffer-full and clears the request. A strobe pulse then clears buffer-full and sets the request.
- R8: Reset clears the command byte, so all ports are inputs with every output-enable low. Reset also clears the output latches and all handshake flags.
- R9: The status read (address 0) returns {2'b00, ieB, intB, bfB, ieA, intA, bfA}, where intX is the gated interrupt.
- R10: An input port without handshake returns the live pin value two clock edges after the pins change.
- R11: Handshake events happen only on the rising edge of the strobe. A strobe that falls and stays low changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects only) |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A pin output |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B pin output |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 6 | Port C pin input |
| pc_out | output | 6 | Port C pin output |
| pc_oe | output | 6 | Port C per-pin output enable |

## Verification
The bench holds a strobe low for several cycles before it releases it. A design that acted on the falling edge would set buffer-full too early. In strobed input mode it changes the pin data after the strobe and before the read. A design that read the live pins instead of the latched byte would return the new value. It masks and then unmasks a pending output interrupt. A design that cleared the request on masking, or that did not gate the pin, would show the wrong interrupt level. It also drives port B's handshake through pins 3 to 5. A design that mapped the port B lines in the wrong order would show buffer-full and the interrupt on the wrong pins.

// File: rtl/hs_port_ctrl.sv
module hs_port_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic       pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic       pb_oe,
  input  logic [5:0] pc_in,
  output logic [5:0] pc_out,
  output logic [5:0] pc_oe
);
  logic [7:0] cmd, a_q, b_q, a_cap, b_cap, a_s1, a_s2, b_s1, b_s2;
  logic [5:0] c_q, c_s1, c_s2;
  logic       stb_a_d, stb_b_d, bf_a, rq_a, bf_b, rq_b;

  wire       ie_a  = cmd[0];
  wire       ie_b  = cmd[1];
  wire       dir_a = cmd[2];
  wire       dir_b = cmd[3];
  wire [1:0] mode  = cmd[5:4];
  wire       ctl_a = (mode == 2'b01) || (mode == 2'b10);
  wire       ctl_b = (mode == 2'b10);
  wire       intr_a = rq_a & ie_a;
  wire       intr_b = rq_b & ie_b;
  wire       rise_a = c_s2[2] & ~stb_a_d;
  wire       rise_b = c_s2[5] & ~stb_b_d;
  wire       wr_a = wr_en && addr == 2'd1;
  wire       wr_b = wr_en && addr == 2'd2;
  wire       rd_a = rd_en && addr == 2'd1;
  wire       rd_b = rd_en && addr == 2'd2;

  always_ff @(posedge clk) begin
    if (rst) begin
      {a_s1, a_s2, b_s1, b_s2} <= '0;
      c_s1 <= '1;
      c_s2 <= '1;
      stb_a_d <= 1'b1;
      stb_b_d <= 1'b1;
    end else begin
      a_s1 <= pa_in;  a_s2 <= a_s1;
      b_s1 <= pb_in;  b_s2 <= b_s1;
      c_s1 <= pc_in;  c_s2 <= c_s1;
      stb_a_d <= c_s2[2];
      stb_b_d <= c_s2[5];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd <= '0; a_q <= '0; b_q <= '0; c_q <= '0;
      a_cap <= '0; b_cap <= '0;
      {bf_a, rq_a, bf_b, rq_b} <= '0;
    end else begin
      if (wr_en && addr == 2'd0) cmd <= wdata;
      if (wr_en && addr == 2'd3) c_q <= wdata[5:0];
      if (rd_a && ctl_a && !dir_a) begin bf_a <= 1'b0; rq_a <= 1'b0; end
      if (rd_b && ctl_b && !dir_b) begin bf_b <= 1'b0; rq_b <= 1'b0; end
      if (rise_a && ctl_a) begin
        rq_a <= 1'b1;
        bf_a <= ~dir_a;
        if (!dir_a) a_cap <= a_s2;
      end
      if (rise_b && ctl_b) begin
        rq_b <= 1'b1;
        bf_b <= ~dir_b;
        if (!dir_b) b_cap <= b_s2;
      end
      if (wr_a) begin
        a_q <= wdata;
        if (ctl_a && dir_a) begin bf_a <= 1'b1; rq_a <= 1'b0; end
      end
      if (wr_b) begin
        b_q <= wdata;
        if (ctl_b && dir_b) begin bf_b <= 1'b1; rq_b <= 1'b0; end
      end
    end
  end

  assign pa_out = a_q;
  assign pb_out = b_q;
  assign pa_oe  = dir_a;
  assign pb_oe  = dir_b;

  always_comb begin
    case (mode)
      2'b00:   begin pc_oe = 6'b000000; pc_out = c_q; end
      2'b01:   begin pc_oe = 6'b111011; pc_out = {c_q[5:3], 1'b0, bf_a, intr_a}; end
      2'b10:   begin pc_oe = 6'b011011; pc_out = {1'b0, bf_b, intr_b, 1'b0, bf_a, intr_a}; end
      default: begin pc_oe = 6'b111111; pc_out = c_q; end
    endcase
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {2'b00, ie_b, intr_b, bf_b, ie_a, intr_a, bf_a};
      2'd1:    rdata = dir_a ? a_q : (ctl_a ? a_cap : a_s2);
      2'd2:    rdata = dir_b ? b_q : (ctl_b ? b_cap : b_s2);
      default: rdata = {2'b00, (pc_oe & pc_out) | (~pc_oe & c_s2)};
    endcase
  end

  assert_reset_inputs_R8: assert property (@(posedge clk)
    rst |=> (pa_oe == 1'b0 && pb_oe == 1'b0 && pc_oe == 6'd0 && pa_out == 8'd0 && pb_out == 8'd0));

  assert_intr_masked_R5: assert property (@(posedge clk) disable iff (rst)
    (ctl_a && !ie_a) |-> !pc_out[0]);

  assert_out_write_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_a && ctl_a && dir_a) |=> (pc_out[1] && !rq_a));

  assert_in_read_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_a && !wr_en && ctl_a && !dir_a && !rise_a) |=> !pc_out[1]);

  assert_all_out_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd0 && wdata[5:4] == 2'b11) |=> pc_oe == 6'h3F);
endmodule

// File: tb/sim_hs_port_ctrl.sv
`timescale 1ns/1ps
module sim_hs_port_ctrl;
  logic       clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, pa_in = '0, pb_in = '0;
  logic [5:0] pc_in = '0;
  logic [7:0] rdata, pa_out, pb_out;
  logic       pa_oe, pb_oe;
  logic [5:0] pc_out, pc_oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hs_port_ctrl u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in), .pc_out(pc_out),
    .pc_oe(pc_oe));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R8 pa_oe", pa_oe, 0);
    check("R8 pb_oe", pb_oe, 0);
    check("R8 pc_oe", pc_oe, 0);
    check("R8 pa_out", pa_out, 0);
    rd(2'd0, d);
    check("R8 status", d, 0);
  endtask

  task automatic t_basic_in();
    logic [7:0] d;
    @(negedge clk); pa_in = 8'h5A;
    cyc(2);
    addr = 2'd1; #1 check("R10 live read", rdata, 8'h5A);
  endtask

  task automatic t_dir();
    logic [7:0] d;
    wr(2'd0, 8'h04);
    wr(2'd1, 8'hC3);
    check("R4 pa_oe", pa_oe, 1);
    check("R4 pa_out", pa_out, 8'hC3);
    rd(2'd1, d);
    check("R4 out read", d, 8'hC3);
    wr(2'd0, 8'h08);
    check("R4 pb_oe", pb_oe, 1);
    check("R4 pa back to input", pa_oe, 0);
  endtask

  task automatic t_pc_modes();
    logic [7:0] d;
    wr(2'd0, 8'h00);
    check("R1 mode00 oe", pc_oe, 0);
    pc_in = 6'h2A; cyc(3);
    rd(2'd3, d);
    check("R1 mode00 read", d, 8'h2A);
    pc_in = 6'h3F; cyc(4);
    wr(2'd0, 8'h30);
    wr(2'd3, 8'h15);
    check("R1 mode11 oe", pc_oe, 6'h3F);
    check("R1 mode11 out", pc_out, 6'h15);
    rd(2'd3, d);
    check("R1 mode11 read", d, 8'h15);
    wr(2'd0, 8'h10);
    wr(2'd3, 8'h38);
    check("R2 mode01 oe", pc_oe, 6'h3B);
    check("R2 mode01 out", pc_out, 6'h38);
    wr(2'd0, 8'h20);
    check("R3 mode10 oe", pc_oe, 6'h1B);
  endtask

  task automatic t_strobe_in();
    logic [7:0] d;
    wr(2'd0, 8'h11);
    pa_in = 8'h77;
    @(negedge clk); pc_in[2] = 1'b0;
    cyc(5);
    check("R11 no action on fall", pc_out[1], 0);
    pc_in[2] = 1'b1; cyc(4);
    check("R6 bf set", pc_out[1], 1);
    check("R6 intr set", pc_out[0], 1);
    pa_in = 8'h00; cyc(3);
    rd(2'd1, d);
    check("R6 latched data", d, 8'h77);
    check("R6 bf cleared", pc_out[1], 0);
    check("R6 intr cleared", pc_out[0], 0);
  endtask

  task automatic t_strobe_out();
    logic [7:0] d;
    wr(2'd0, 8'h15);
    wr(2'd1, 8'h9C);
    check("R7 data out", pa_out, 8'h9C);
    check("R7 bf set", pc_out[1], 1);
    check("R7 intr clear", pc_out[0], 0);
    @(negedge clk); pc_in[2] = 1'b0; cyc(3);
    pc_in[2] = 1'b1; cyc(4);
    check("R7 bf cleared", pc_out[1], 0);
    check("R7 intr raised", pc_out[0], 1);
    rd(2'd0, d);
    check("R9 status A", d, 8'h06);
    wr(2'd0, 8'h14);
    check("R5 masked", pc_out[0], 0);
    wr(2'd0, 8'h15);
    check("R5 unmasked", pc_out[0], 1);
    wr(2'd0, 8'h14);
  endtask

  task automatic t_port_b();
    logic [7:0] d;
    wr(2'd0, 8'h22);
    pb_in = 8'hE1;
    @(negedge clk); pc_in[5] = 1'b0; cyc(3);
    pc_in[5] = 1'b1; cyc(4);
    check("R3 B bf pin4", pc_out[4], 1);
    check("R3 B intr pin3", pc_out[3], 1);
    check("R3 A pins quiet", pc_out[1:0], 0);
    rd(2'd0, d);
    check("R9 status B", d, 8'h38);
    rd(2'd2, d);
    check("R6 B data", d, 8'hE1);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_basic_in();
    t_dir();
    t_pc_modes();
    t_strobe_in();
    t_strobe_out();
    t_port_b();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule